// File: doc/BRIEF.md
# Lane-Parallel Matrix-Vector Dot-Product Engine

This block multiplies a matrix by a vector held on chip. The vector is written first, one element at a time, through a dedicated write port. The matrix then streams in by rows, left to right. Each beat carries `LANES` consecutive elements of the current row. Every lane multiplies its element by the matching vector entry and folds the product into its own running sum. When a row's last beat has gone through the accumulator, the lane sums are added together and the row's dot product appears on the result port for one cycle.

Each lane's running sum sits behind an adder pipeline that is `LAT` cycles deep. A product can only join the sum once the previous addition has left that pipeline. The block therefore throttles its own input. After every accepted beat, `mat_ready` stays low until the loop is free again. The vector stays in place and is reused for every row. It may be rewritten between matrices, and the same vector can serve any number of them. All arithmetic is signed two's-complement integer.

Top module: `rdot_engine`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `res_valid` and `res_last` low and `mat_ready` high. Any partly accumulated row is discarded.
- R2: A cycle with `vec_we` high stores `vec_data` into vector entry `vec_addr`. Entries keep their value until rewritten, and every row of every following matrix uses them.
- R3: Beat k of a row carries columns k*LANES to k*LANES+LANES-1. Lane l sits in bits [l*DATA_W +: DATA_W] of `mat_data` and holds column k*LANES+l. Rows arrive in order 0 to ROWS-1, so row i, column j is stream element i*COLS+j.
- R4: The result of row i is the sum over all columns j of a[i][j]*v[j]. Both operands are signed DATA_W-bit values. The sum is given as an ACC_W-bit two's-complement value, with ACC_W = 2*DATA_W + clog2(COLS).
- R5: A beat is accepted on an edge where `mat_valid` and `mat_ready` are both high. After an accepted beat, `mat_ready` is low for the next LAT-1 cycles and then high again. Two accepts are therefore never closer than LAT edges.
- R6: Lane sums start from zero on every row's first beat. A row's result does not depend on earlier rows.
- R7: Exactly one `res_valid` pulse is produced per completed row. It is visible in the cycle after the LAT-th edge that follows the edge accepting the row's last beat.
- R8: `res_last` is high together with `res_valid` only for row ROWS-1. After that row the row count restarts at 0 for the next matrix.
- R9: Cycles with `mat_valid` low accept nothing and change no result, whatever `mat_data` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vec_we | input | 1 | Vector entry write strobe |
| vec_addr | input | VA_W | Vector entry index |
| vec_data | input | DATA_W | Signed vector entry value |
| mat_valid | input | 1 | Matrix beat present |
| mat_ready | output | 1 | Engine can take a beat this cycle |
| mat_data | input | LANES*DATA_W | LANES signed matrix elements, lane 0 in the low bits |
| res_valid | output | 1 | Row result strobe |
| res_data | output | ACC_W | Signed row dot product |
| res_last | output | 1 | Result belongs to the final matrix row |

## Verification
The assertions assume the design parameters meet three conditions: LANES divides COLS, LANES does not exceed COLS, and LAT is at least one. They also assume reset is held for at least one edge before any stream starts. The bench keeps to these conditions by using the defaults. It writes vector entries only while no row is partly streamed. It holds `mat_valid` and `mat_data` steady until a beat is accepted, and drives random data only on idle cycles where `mat_valid` is low. A mid-row reset shows that an abandoned row leaves no trace in the following matrix.

// File: rtl/rdot_pkg.sv
package rdot_pkg;

    // Width of an index that counts 0..n-1 (at least one bit).
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Result width: one full product plus growth for COLS terms.
    function automatic int acc_w(input int dw, input int cols);
        return 2 * dw + idx_w(cols);
    endfunction

    // Marker that travels beside each accepted beat through the adder loop.
    typedef struct packed {
        logic row_end;
        logic last_row;
    } beat_tag_t;

    // Accumulation loop state as seen by the input side.
    typedef enum logic [0:0] {
        LOOP_FREE = 1'b0,
        LOOP_BUSY = 1'b1
    } loop_state_e;

endpackage

// File: rtl/rdot_ctrl.sv
module rdot_ctrl #(
    parameter int LANES = 4,
    parameter int COLS  = 16,
    parameter int ROWS  = 4,
    parameter int LAT   = 3,
    localparam int BEATS  = COLS / LANES,
    localparam int BEAT_W = rdot_pkg::idx_w(BEATS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mat_valid,
    output logic              mat_ready,
    output logic              accept,
    output logic [BEAT_W-1:0] beat_idx,
    output logic              row_first,
    output logic [LAT-1:0]    stg_vld,
    output logic              fin,
    output logic              fin_last
);
    import rdot_pkg::*;

    localparam int ROW_W = idx_w(ROWS);
    localparam int GAP_W = idx_w(LAT);

    logic [GAP_W-1:0]  gap_q;
    logic [BEAT_W-1:0] beat_q;
    logic [ROW_W-1:0]  row_q;
    loop_state_e       state;
    beat_tag_t         tag_in;
    beat_tag_t         tag_q [LAT];
    logic [LAT-1:0]    vld_q;

    assign state     = (gap_q == '0) ? LOOP_FREE : LOOP_BUSY;
    assign mat_ready = (state == LOOP_FREE);
    assign accept    = mat_valid && mat_ready;
    assign beat_idx  = beat_q;
    assign row_first = (beat_q == '0);

    always_comb begin
        tag_in.row_end  = (beat_q == BEAT_W'(BEATS - 1));
        tag_in.last_row = (row_q == ROW_W'(ROWS - 1));
    end

    // Gap counter: the loop needs LAT cycles before it can take the next beat.
    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q <= '0;
        end else if (accept) begin
            gap_q <= GAP_W'(LAT - 1);
        end else if (gap_q != '0) begin
            gap_q <= gap_q - 1'b1;
        end
    end

    // Position inside the matrix.
    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q <= '0;
            row_q  <= '0;
        end else if (accept) begin
            if (tag_in.row_end) begin
                beat_q <= '0;
                row_q  <= tag_in.last_row ? '0 : row_q + 1'b1;
            end else begin
                beat_q <= beat_q + 1'b1;
            end
        end
    end

    // Token and tag pipeline that runs beside the lane adders.
    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
            for (int k = 0; k < LAT; k++) begin
                tag_q[k] <= '0;
            end
        end else begin
            vld_q[0] <= accept;
            if (accept) begin
                tag_q[0] <= tag_in;
            end
            for (int k = 1; k < LAT; k++) begin
                vld_q[k] <= vld_q[k-1];
                if (vld_q[k-1]) begin
                    tag_q[k] <= tag_q[k-1];
                end
            end
        end
    end

    assign stg_vld  = vld_q;
    assign fin      = vld_q[LAT-1] && tag_q[LAT-1].row_end;
    assign fin_last = tag_q[LAT-1].last_row;

endmodule

// File: rtl/rdot_vecbuf.sv
module rdot_vecbuf #(
    parameter int DATA_W = 8,
    parameter int LANES  = 4,
    parameter int COLS   = 16,
    localparam int VA_W   = rdot_pkg::idx_w(COLS),
    localparam int BEAT_W = rdot_pkg::idx_w(COLS / LANES)
) (
    input  logic                         clk,
    input  logic                         we,
    input  logic [VA_W-1:0]              waddr,
    input  logic [DATA_W-1:0]            wdata,
    input  logic [BEAT_W-1:0]            beat_idx,
    output logic [LANES-1:0][DATA_W-1:0] rd
);
    logic [DATA_W-1:0] mem_q [COLS];

    always_ff @(posedge clk) begin
        if (we && (int'(waddr) < COLS)) begin
            mem_q[waddr] <= wdata;
        end
    end

    // Lane l of beat b reads entry b*LANES + l.
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            rd[l] = mem_q[VA_W'(int'(beat_idx) * LANES + l)];
        end
    end

endmodule

// File: rtl/rdot_lane.sv
module rdot_lane #(
    parameter int DATA_W = 8,
    parameter int ACC_W  = 20,
    parameter int LAT    = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              row_first,
    input  logic [LAT-1:0]    stg_vld,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] v_i,
    output logic [ACC_W-1:0]  sum_o
);
    localparam int PW = 2 * DATA_W;

    logic signed [PW-1:0] prod;
    logic [ACC_W-1:0]     prod_ext;
    logic [ACC_W-1:0]     base;
    logic [ACC_W-1:0]     stg_q [LAT];

    assign prod     = $signed(a_i) * $signed(v_i);
    assign prod_ext = {{(ACC_W - PW){prod[PW-1]}}, prod};
    // The running sum is whatever has left the adder pipeline last.
    assign base     = row_first ? '0 : stg_q[LAT-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < LAT; k++) begin
                stg_q[k] <= '0;
            end
        end else begin
            if (accept) begin
                stg_q[0] <= base + prod_ext;
            end
            for (int k = 1; k < LAT; k++) begin
                if (stg_vld[k-1]) begin
                    stg_q[k] <= stg_q[k-1];
                end
            end
        end
    end

    assign sum_o = stg_q[LAT-1];

endmodule

// File: rtl/rdot_reduce.sv
module rdot_reduce #(
    parameter int LANES = 4,
    parameter int ACC_W = 20
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        fin,
    input  logic                        fin_last,
    input  logic [LANES-1:0][ACC_W-1:0] lane_sum,
    output logic                        res_valid,
    output logic [ACC_W-1:0]            res_data,
    output logic                        res_last
);
    logic [ACC_W-1:0] total;

    always_comb begin
        total = '0;
        for (int l = 0; l < LANES; l++) begin
            total = total + lane_sum[l];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_last  <= 1'b0;
            res_data  <= '0;
        end else begin
            res_valid <= fin;
            res_last  <= fin && fin_last;
            if (fin) begin
                res_data <= total;
            end
        end
    end

endmodule

// File: rtl/rdot_engine.sv
module rdot_engine #(
    parameter int DATA_W = 8,
    parameter int LANES  = 4,
    parameter int COLS   = 16,
    parameter int ROWS   = 4,
    parameter int LAT    = 3,
    localparam int ACC_W = rdot_pkg::acc_w(DATA_W, COLS),
    localparam int VA_W  = rdot_pkg::idx_w(COLS)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    vec_we,
    input  logic [VA_W-1:0]         vec_addr,
    input  logic [DATA_W-1:0]       vec_data,
    input  logic                    mat_valid,
    output logic                    mat_ready,
    input  logic [LANES*DATA_W-1:0] mat_data,
    output logic                    res_valid,
    output logic [ACC_W-1:0]        res_data,
    output logic                    res_last
);
    localparam int BEAT_W = rdot_pkg::idx_w(COLS / LANES);

    logic                         accept;
    logic [BEAT_W-1:0]            beat_idx;
    logic                         row_first;
    logic [LAT-1:0]               stg_vld;
    logic                         fin;
    logic                         fin_last;
    logic [LANES-1:0][DATA_W-1:0] mat_lanes;
    logic [LANES-1:0][DATA_W-1:0] vec_lanes;
    logic [LANES-1:0][ACC_W-1:0]  lane_sum;

    assign mat_lanes = mat_data;

    rdot_ctrl #(
        .LANES(LANES), .COLS(COLS), .ROWS(ROWS), .LAT(LAT)
    ) ctrl_i (
        .clk      (clk),
        .rst      (rst),
        .mat_valid(mat_valid),
        .mat_ready(mat_ready),
        .accept   (accept),
        .beat_idx (beat_idx),
        .row_first(row_first),
        .stg_vld  (stg_vld),
        .fin      (fin),
        .fin_last (fin_last)
    );

    rdot_vecbuf #(
        .DATA_W(DATA_W), .LANES(LANES), .COLS(COLS)
    ) vbuf_i (
        .clk     (clk),
        .we      (vec_we),
        .waddr   (vec_addr),
        .wdata   (vec_data),
        .beat_idx(beat_idx),
        .rd      (vec_lanes)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        rdot_lane #(
            .DATA_W(DATA_W), .ACC_W(ACC_W), .LAT(LAT)
        ) lane_i (
            .clk      (clk),
            .rst      (rst),
            .accept   (accept),
            .row_first(row_first),
            .stg_vld  (stg_vld),
            .a_i      (mat_lanes[l]),
            .v_i      (vec_lanes[l]),
            .sum_o    (lane_sum[l])
        );
    end

    rdot_reduce #(
        .LANES(LANES), .ACC_W(ACC_W)
    ) red_i (
        .clk      (clk),
        .rst      (rst),
        .fin      (fin),
        .fin_last (fin_last),
        .lane_sum (lane_sum),
        .res_valid(res_valid),
        .res_data (res_data),
        .res_last (res_last)
    );

endmodule

// File: rtl/rdot_engine_chk.sv
module rdot_engine_chk #(
    parameter int LANES = 4,
    parameter int COLS  = 16,
    parameter int LAT   = 3
) (
    input logic clk,
    input logic rst,
    input logic mat_valid,
    input logic mat_ready,
    input logic res_valid,
    input logic res_last
);
    localparam int BEATS = COLS / LANES;
    localparam int BW    = rdot_pkg::idx_w(BEATS);
    localparam int GW    = rdot_pkg::idx_w(LAT + 1);

    logic          took;
    logic [GW-1:0] since_q;
    logic [BW-1:0] beat_q;
    logic [3:0]    owed_q;
    logic          row_done;

    assign took     = mat_valid && mat_ready;
    assign row_done = took && (beat_q == BW'(BEATS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            since_q <= GW'(LAT);
            beat_q  <= '0;
            owed_q  <= '0;
        end else begin
            if (took) begin
                since_q <= '0;
            end else if (since_q < GW'(LAT)) begin
                since_q <= since_q + 1'b1;
            end
            if (took) begin
                beat_q <= row_done ? '0 : beat_q + 1'b1;
            end
            if (row_done && !res_valid) begin
                owed_q <= owed_q + 1'b1;
            end else if (!row_done && res_valid && owed_q != '0) begin
                owed_q <= owed_q - 1'b1;
            end
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!res_valid && !res_last && mat_ready));

    assert_accept_spacing_R5: assert property (@(posedge clk) disable iff (rst)
        took |-> (since_q >= GW'(LAT - 1)));

    assert_result_owed_R7: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (owed_q != '0));

    assert_last_with_valid_R8: assert property (@(posedge clk) disable iff (rst)
        res_last |-> res_valid);

endmodule

bind rdot_engine rdot_engine_chk #(
    .LANES(LANES), .COLS(COLS), .LAT(LAT)
) chk_i (
    .clk      (clk),
    .rst      (rst),
    .mat_valid(mat_valid),
    .mat_ready(mat_ready),
    .res_valid(res_valid),
    .res_last (res_last)
);

// File: tb/rdot_engine_tb_top.sv
module rdot_engine_tb_top;
    localparam int DATA_W = 8;
    localparam int LANES  = 4;
    localparam int COLS   = 16;
    localparam int ROWS   = 4;
    localparam int LAT    = 3;
    localparam int BEATS  = COLS / LANES;
    localparam int ACC_W  = 2 * DATA_W + $clog2(COLS);
    localparam int VA_W   = $clog2(COLS);

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    vec_we = 1'b0;
    logic [VA_W-1:0]         vec_addr = '0;
    logic [DATA_W-1:0]       vec_data = '0;
    logic                    mat_valid = 1'b0;
    logic                    mat_ready;
    logic [LANES*DATA_W-1:0] mat_data = '0;
    logic                    res_valid;
    logic [ACC_W-1:0]        res_data;
    logic                    res_last;

    always #10 clk = ~clk;

    rdot_engine #(
        .DATA_W(DATA_W), .LANES(LANES), .COLS(COLS), .ROWS(ROWS), .LAT(LAT)
    ) dut_i (
        .clk(clk), .rst(rst), .vec_we(vec_we), .vec_addr(vec_addr),
        .vec_data(vec_data), .mat_valid(mat_valid), .mat_ready(mat_ready),
        .mat_data(mat_data), .res_valid(res_valid), .res_data(res_data),
        .res_last(res_last)
    );

    int    n_checks = 0;
    int    n_errors = 0;
    string phase_tag = "R1";

    // Reference model state.
    int               vec_m [COLS];
    int               cyc = 0;
    int               last_edge = -1000;
    int               m_beat = 0;
    int               m_row = 0;
    int               m_sum = 0;
    int               due_q [$];
    logic [ACC_W-1:0] dat_q [$];
    bit               lst_q [$];

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    // Compare with the model every cycle, 15 ns after the rising edge.
    always begin
        @(posedge clk);
        cyc++;
        #15;
        if (cyc > 150000) begin
            check(1'b0, "R7", "watchdog expired", cyc, 150000);
            finish_run();
        end
        if (rst) begin
            due_q.delete(); dat_q.delete(); lst_q.delete();
            m_beat = 0; m_row = 0; m_sum = 0; last_edge = -1000;
        end else begin
            bit exp_rdy;
            bit exp_vld;
            exp_rdy = (cyc >= last_edge + LAT - 1);
            check(mat_ready == exp_rdy, "R5", "mat_ready", mat_ready, exp_rdy);
            exp_vld = (due_q.size() > 0) && (due_q[0] == cyc);
            check(res_valid == exp_vld, "R7", "res_valid", res_valid, exp_vld);
            if (exp_vld) begin
                check(res_data == dat_q[0], phase_tag, "res_data",
                      longint'($signed(res_data)), longint'($signed(dat_q[0])));
                check(res_last == lst_q[0], "R8", "res_last", res_last, lst_q[0]);
                void'(due_q.pop_front()); void'(dat_q.pop_front()); void'(lst_q.pop_front());
            end else if (!res_valid) begin
                check(!res_last, "R8", "res_last without result", res_last, 0);
            end
            if (mat_valid && mat_ready) begin
                for (int l = 0; l < LANES; l++) begin
                    m_sum += int'($signed(mat_data[l*DATA_W +: DATA_W])) * vec_m[m_beat*LANES + l];
                end
                last_edge = cyc + 1;
                if (m_beat == BEATS - 1) begin
                    due_q.push_back(cyc + 1 + LAT);
                    dat_q.push_back(ACC_W'(m_sum));
                    lst_q.push_back(m_row == ROWS - 1);
                    m_sum  = 0;
                    m_beat = 0;
                    m_row  = (m_row == ROWS - 1) ? 0 : m_row + 1;
                end else begin
                    m_beat++;
                end
            end
        end
    end

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #5;
        end
    endtask

    task automatic write_vec(input int idx, input int val);
        vec_we = 1'b1; vec_addr = VA_W'(idx); vec_data = DATA_W'(val);
        vec_m[idx] = int'($signed(DATA_W'(val)));
        @(posedge clk); #5;
        vec_we = 1'b0;
    endtask

    function automatic int elem(input int pat, input int r, input int c);
        case (pat)
            1: return -128;
            2: return ((r + c) % 2 == 0) ? 127 : -128;
            3: return (c == (r * 5 + 3) % COLS) ? 1 : 0;
            4: return 0;
            default: return int'($urandom_range(0, 255)) - 128;
        endcase
    endfunction

    task automatic send_beat(input logic [LANES*DATA_W-1:0] d, input int gap_max);
        bit took;
        if (gap_max > 0) begin
            int idle = int'($urandom_range(0, gap_max));
            for (int i = 0; i < idle; i++) begin
                mat_valid = 1'b0; mat_data = LANES*DATA_W'($urandom);
                @(posedge clk); #5;
            end
        end
        mat_valid = 1'b1; mat_data = d;
        took = 1'b0;
        while (!took) begin
            took = mat_ready;
            @(posedge clk); #5;
        end
        mat_valid = 1'b0;
    endtask

    task automatic run_matrix(input int pat, input int gap_max, input int n_beats);
        int sent = 0;
        for (int r = 0; r < ROWS; r++) begin
            for (int b = 0; b < BEATS; b++) begin
                logic [LANES*DATA_W-1:0] d;
                for (int l = 0; l < LANES; l++) begin
                    d[l*DATA_W +: DATA_W] = DATA_W'(elem(pat, r, b*LANES + l));
                end
                if (sent < n_beats) send_beat(d, gap_max);
                sent++;
            end
        end
    endtask

    task automatic drain();
        wait_cycles(3 * LAT + 6);
        check(due_q.size() == 0, "R7", "results still owed", due_q.size(), 0);
    endtask

    initial begin
        wait_cycles(3);
        rst = 1'b0;
        wait_cycles(1);
        // R1: quiet outputs straight after reset.
        check(res_valid == 1'b0, "R1", "res_valid after reset", res_valid, 0);
        check(res_last == 1'b0, "R1", "res_last after reset", res_last, 0);
        check(mat_ready == 1'b1, "R1", "mat_ready after reset", mat_ready, 1);

        // R2 R3 R4 R6: random vector, random matrix, back-to-back beats.
        for (int j = 0; j < COLS; j++) write_vec(j, int'($urandom_range(0, 255)) - 128);
        phase_tag = "R4";
        run_matrix(0, 0, ROWS * BEATS);
        phase_tag = "R6";
        run_matrix(0, 0, ROWS * BEATS);
        drain();

        // R9: idle cycles with random data between beats.
        phase_tag = "R9";
        run_matrix(0, 5, ROWS * BEATS);
        drain();

        // R4 extremes: every element and entry at the negative limit, then mixed limits.
        for (int j = 0; j < COLS; j++) write_vec(j, -128);
        phase_tag = "R4";
        run_matrix(1, 0, ROWS * BEATS);
        for (int j = 0; j < COLS; j++) write_vec(j, (j % 3 == 0) ? 127 : -128);
        run_matrix(2, 1, ROWS * BEATS);
        drain();

        // R3: one-hot rows against an index vector expose the lane and column order.
        for (int j = 0; j < COLS; j++) write_vec(j, j + 1);
        phase_tag = "R3";
        run_matrix(3, 0, ROWS * BEATS);
        drain();

        // R2: rewrite single entries and reuse the vector again.
        write_vec(3, -77);
        write_vec(COLS - 1, 99);
        phase_tag = "R2";
        run_matrix(0, 2, ROWS * BEATS);
        run_matrix(4, 0, ROWS * BEATS);
        drain();

        // R1 and R6: reset in the middle of a row, then a clean matrix.
        phase_tag = "R1";
        run_matrix(0, 0, BEATS + 2);
        rst = 1'b1;
        wait_cycles(2);
        rst = 1'b0;
        wait_cycles(1);
        check(res_valid == 1'b0, "R1", "res_valid after mid-row reset", res_valid, 0);
        check(mat_ready == 1'b1, "R1", "mat_ready after mid-row reset", mat_ready, 1);
        phase_tag = "R6";
        run_matrix(0, 1, ROWS * BEATS);
        drain();

        finish_run();
    end

endmodule